// File: doc/BRIEF.md
# LIN Master Header Generator

This block sends the header of a LIN frame on a single transmit line. When software or a controller issues a start command, the block captures the 6-bit identifier and the configuration codes, then drives the header. The header consists of a dominant (low) break, a recessive gap, the sync byte, a second gap, and the protected identifier byte. Each byte is sent LSB first, with one start bit and one stop bit. Every bit lasts one period of an external bit-time tick, so the block has no baud-rate logic of its own.

Two codes set the header timing. The break code gives a dominant break of 13, 17, 21 or 26 bit times. The delay code sets the two gaps, and the two gaps differ for the same code. The break-to-sync gap is 1, 4, 8 or 14 bit times, and it follows one mandatory recessive bit after the break. The sync-to-identifier gap is 1, 4, 4 or 4 bit times. In direct mode (auto mode off) the programmed gaps are left out: only the mandatory recessive bit separates break and sync, and the identifier byte starts right after the sync stop bit. A busy flag covers the whole sequence, and a one-cycle done pulse marks its end.

Top module: `lin_hdr_gen`

## Requirements
- R1: During and after reset `tx_o` is 1 (recessive), `busy_o` is 0 and `done_o` is 0, and `tx_o` stays 1 whenever `busy_o` is 0.
- R2: The break holds `tx_o` at 0 for a number of bit times set by `brk_code_i` (captured at start): 0 gives 13, 1 gives 17, 2 gives 21, 3 gives 26.
- R3: In auto mode (`auto_i`=1) the break is followed by 1 recessive bit plus a gap set by `dly_code_i`: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14 bit times, all with `tx_o`=1.
- R4: The sync field is 10 bits: a start bit 0, the data byte 0x55 LSB first, and a stop bit 1.
- R5: In auto mode the sync stop bit is followed by a recessive gap set by `dly_code_i`: 0 gives 1 bit time, and 1, 2 and 3 give 4 bit times.
- R6: In direct mode (`auto_i`=0) exactly one recessive bit separates the break and the sync start bit, and the identifier start bit follows the sync stop bit directly.
- R7: The identifier field is a start bit 0, then byte {P1,P0,id[5:0]} LSB first, then a stop bit 1. P0 is in bit 6 and equals id0^id1^id2^id4. P1 is in bit 7 and equals the inverse of id1^id3^id4^id5.
- R8: `done_o` is a single-cycle pulse in the cycle after the tick that ends the identifier stop bit, and `busy_o` falls in that same cycle.
- R9: A start command while `busy_o` is 1 is ignored. Changes to identifier, code or mode inputs after the start have no effect on the header in progress.
- R10: `busy_o` rises in the cycle after a start accepted while idle. `tx_o` changes only in the cycle that follows a cycle with `bit_tick_i` high, and the first break bit begins at the first tick after the start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse marking each bit-time boundary |
| start_i | input | 1 | Start a header (accepted only when idle) |
| auto_i | input | 1 | 1: insert programmed gaps; 0: direct mode without gaps |
| id_i | input | 6 | Frame identifier |
| brk_code_i | input | 2 | Break length code |
| dly_code_i | input | 2 | Inter-field gap code |
| tx_o | output | 1 | Transmit line, 1 is recessive |
| busy_o | output | 1 | High from accepted start until done |
| done_o | output | 1 | One-cycle pulse at the end of the header |

## Verification
The assertions assume that all inputs are synchronous to `clk_i` and that `bit_tick_i` is a single-cycle pulse. The configuration check also assumes that the captured identifier and codes may change only while the block is idle. The stimulus drives every input on the falling clock edge. It raises the tick for one cycle out of every four, and it holds a start for exactly one cycle. Some runs send a second start, with the identifier, codes and mode all inverted, in the middle of a header. This exercises the ignore path while the inputs still change only synchronously.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
  localparam int unsigned FRAME_BITS = 10;
  localparam logic [7:0]  SYNC_BYTE  = 8'h55;

  typedef enum logic [2:0] {
    SEG_IDLE, SEG_ARM, SEG_BRK, SEG_GAP1, SEG_SYNC, SEG_GAP2, SEG_PID
  } seg_e;

  typedef struct packed {
    logic       auto_tx;
    logic [1:0] dly;
    logic [1:0] brk;
    logic [5:0] id;
  } hdr_cfg_t;
endpackage

// File: rtl/lin_pid_calc.sv
module lin_pid_calc (
  input  logic [5:0] id_i,
  output logic [7:0] pid_o
);
  logic p0, p1;
  assign p0    = id_i[0] ^ id_i[1] ^ id_i[2] ^ id_i[4];
  assign p1    = ~(id_i[1] ^ id_i[3] ^ id_i[4] ^ id_i[5]);
  assign pid_o = {p1, p0, id_i};
endmodule

// File: rtl/lin_hdr_len_dec.sv
module lin_hdr_len_dec #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             auto_i,
  input  logic [1:0]       brk_code_i,
  input  logic [1:0]       dly_code_i,
  output logic [CNT_W-1:0] brk_len_o,
  output logic [CNT_W-1:0] gap1_len_o,  // includes mandatory recessive bit
  output logic [CNT_W-1:0] gap2_len_o   // zero means skip
);
  logic [CNT_W-1:0] gap1_prog;

  always_comb begin
    unique case (brk_code_i)
      2'd0: brk_len_o = CNT_W'(13);
      2'd1: brk_len_o = CNT_W'(17);
      2'd2: brk_len_o = CNT_W'(21);
      default: brk_len_o = CNT_W'(26);
    endcase
    unique case (dly_code_i)
      2'd0: gap1_prog = CNT_W'(1);
      2'd1: gap1_prog = CNT_W'(4);
      2'd2: gap1_prog = CNT_W'(8);
      default: gap1_prog = CNT_W'(14);
    endcase
    gap1_len_o = auto_i ? gap1_prog + CNT_W'(1) : CNT_W'(1);
    if (!auto_i)                gap2_len_o = '0;
    else if (dly_code_i == 2'd0) gap2_len_o = CNT_W'(1);
    else                        gap2_len_o = CNT_W'(4);
  end
endmodule

// File: rtl/lin_frame_shift.sv
module lin_frame_shift #(
  parameter int unsigned FW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic [FW-3:0] byte_i,
  output logic          bit_o
);
  logic [FW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '1;
    else if (load_i)  sh_q <= {1'b1, byte_i, 1'b0};
    else if (shift_i) sh_q <= {1'b1, sh_q[FW-1:1]};
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/lin_hdr_gen.sv
module lin_hdr_gen
  import lin_hdr_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_tick_i,
  input  logic       start_i,
  input  logic       auto_i,
  input  logic [5:0] id_i,
  input  logic [1:0] brk_code_i,
  input  logic [1:0] dly_code_i,
  output logic       tx_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);

  seg_e             seg_q;
  logic [CNT_W-1:0] cnt_q;
  hdr_cfg_t         cfg_q;
  logic             done_q;

  logic [CNT_W-1:0] brk_len, gap1_len, gap2_len;
  logic [7:0]       pid;
  logic             start_ok, seg_end, fr_load, fr_shift, fr_bit;
  logic [7:0]       fr_byte;

  lin_hdr_len_dec #(.CNT_W(CNT_W)) u_len (
    .auto_i    (cfg_q.auto_tx),
    .brk_code_i(cfg_q.brk),
    .dly_code_i(cfg_q.dly),
    .brk_len_o (brk_len),
    .gap1_len_o(gap1_len),
    .gap2_len_o(gap2_len)
  );

  lin_pid_calc u_pid (
    .id_i (cfg_q.id),
    .pid_o(pid)
  );

  assign start_ok = start_i && (seg_q == SEG_IDLE);
  assign seg_end  = bit_tick_i && (cnt_q == '0);

  // byte frames are loaded on the tick that enters them
  assign fr_load  = seg_end && ((seg_q == SEG_GAP1) || (seg_q == SEG_GAP2) ||
                                ((seg_q == SEG_SYNC) && (gap2_len == '0)));
  assign fr_byte  = (seg_q == SEG_GAP1) ? SYNC_BYTE : pid;
  assign fr_shift = bit_tick_i && (cnt_q != '0) &&
                    ((seg_q == SEG_SYNC) || (seg_q == SEG_PID));

  lin_frame_shift #(.FW(FRAME_BITS)) u_frm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (fr_load),
    .shift_i(fr_shift),
    .byte_i (fr_byte),
    .bit_o  (fr_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= SEG_IDLE;
      cnt_q  <= '0;
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        seg_q <= SEG_ARM;
        cnt_q <= '0;
        cfg_q <= '{auto_tx: auto_i, dly: dly_code_i, brk: brk_code_i, id: id_i};
      end else if (bit_tick_i && (seg_q != SEG_IDLE)) begin
        if (seg_q == SEG_ARM) begin
          seg_q <= SEG_BRK;
          cnt_q <= brk_len - CNT_W'(1);
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end else begin
          unique case (seg_q)
            SEG_BRK: begin
              seg_q <= SEG_GAP1;
              cnt_q <= gap1_len - CNT_W'(1);
            end
            SEG_GAP1: begin
              seg_q <= SEG_SYNC;
              cnt_q <= FRAME_LAST;
            end
            SEG_SYNC: begin
              if (gap2_len == '0) begin
                seg_q <= SEG_PID;
                cnt_q <= FRAME_LAST;
              end else begin
                seg_q <= SEG_GAP2;
                cnt_q <= gap2_len - CNT_W'(1);
              end
            end
            SEG_GAP2: begin
              seg_q <= SEG_PID;
              cnt_q <= FRAME_LAST;
            end
            SEG_PID: begin
              seg_q  <= SEG_IDLE;
              done_q <= 1'b1;
            end
            default: seg_q <= SEG_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    unique case (seg_q)
      SEG_BRK:           tx_o = 1'b0;
      SEG_SYNC, SEG_PID: tx_o = fr_bit;
      default:           tx_o = 1'b1;
    endcase
  end

  assign busy_o = (seg_q != SEG_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/lin_hdr_gen_chk.sv
module lin_hdr_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bit_tick_i,
  input logic        start_i,
  input logic        tx_o,
  input logic        busy_o,
  input logic        done_o,
  input logic [10:0] cfg_q
);
  p_idle_tx_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);

  p_tx_on_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bit_tick_i) |-> $stable(tx_o));

  p_busy_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_ends_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_cfg_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cfg_q));
endmodule

bind lin_hdr_gen lin_hdr_gen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_tick_i(bit_tick_i),
  .start_i   (start_i),
  .tx_o      (tx_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .cfg_q     (cfg_q)
);

// File: tb/lin_hdr_gen_tb.sv
module lin_hdr_gen_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_tick_i = 1'b0;
  logic       start_i = 1'b0;
  logic       auto_i = 1'b0;
  logic [5:0] id_i = '0;
  logic [1:0] brk_code_i = '0;
  logic [1:0] dly_code_i = '0;
  logic       tx_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lin_hdr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_tick_i(bit_tick_i), .start_i(start_i),
    .auto_i(auto_i), .id_i(id_i), .brk_code_i(brk_code_i), .dly_code_i(dly_code_i),
    .tx_o(tx_o), .busy_o(busy_o), .done_o(done_o)
  );

  // {auto, dly, brk, id, expected protected id}
  localparam int NVEC = 6;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 2'd0, 6'h00, 8'h80},
    {1'b1, 2'd1, 2'd1, 6'h3C, 8'h3C},
    {1'b1, 2'd2, 2'd2, 6'h01, 8'hC1},
    {1'b1, 2'd3, 2'd3, 6'h2A, 8'h6A},
    {1'b0, 2'd3, 2'd1, 6'h3F, 8'hBF},
    {1'b0, 2'd0, 2'd3, 6'h12, 8'h92}
  };

  // one-cycle tick every fourth clock
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % 4;
      bit_tick_i = (div == 3);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (bit_tick_i !== 1'b1);
    @(negedge clk);
  endtask

  task automatic run_hdr(input logic [18:0] v, input bit poke);
    logic       a  = v[18];
    logic [1:0] dl = v[17:16];
    logic [1:0] bk = v[15:14];
    logic [5:0] id = v[13:8];
    logic [7:0] pid = v[7:0];
    int blen, g1, g2, len, p;
    logic stream [0:127];
    string tag;
    blen = (bk == 0) ? 13 : (bk == 1) ? 17 : (bk == 2) ? 21 : 26;
    g1 = a ? ((dl == 0) ? 1 : (dl == 1) ? 4 : (dl == 2) ? 8 : 14) : 0;
    g2 = a ? ((dl == 0) ? 1 : 4) : 0;
    p = 0;
    for (int i = 0; i < blen; i++) begin stream[p] = 1'b0; p++; end
    for (int i = 0; i < 1 + g1; i++) begin stream[p] = 1'b1; p++; end
    stream[p] = 1'b0; p++;
    for (int i = 0; i < 8; i++) begin stream[p] = i[0] ? 1'b0 : 1'b1; p++; end
    stream[p] = 1'b1; p++;
    for (int i = 0; i < g2; i++) begin stream[p] = 1'b1; p++; end
    stream[p] = 1'b0; p++;
    for (int i = 0; i < 8; i++) begin stream[p] = pid[i]; p++; end
    stream[p] = 1'b1; p++;
    len = p;

    @(negedge clk);
    auto_i = a; dly_code_i = dl; brk_code_i = bk; id_i = id; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R10 busy after start", busy_o, 1);
    for (int k = 0; k < len; k++) begin
      wait_tick();
      if (k < blen)                         tag = "R2 break";
      else if (k < blen + 1 + g1)           tag = a ? "R3 gap1" : "R6 direct gap";
      else if (k < blen + 11 + g1)          tag = "R4 sync";
      else if (k < blen + 11 + g1 + g2)     tag = "R5 gap2";
      else                                  tag = a ? "R7 pid" : "R7 pid R6";
      check(tx_o === stream[k], $sformatf("%s bit %0d", tag, k), tx_o, stream[k]);
      if (poke && k == 5) begin
        auto_i = ~a; dly_code_i = ~dl; brk_code_i = ~bk; id_i = ~id; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R9 busy kept", busy_o, 1);
      end
    end
    wait_tick();
    check(done_o === 1'b1, "R8 done pulse", done_o, 1);
    check(busy_o === 1'b0, "R8 busy falls", busy_o, 0);
    check(tx_o === 1'b1, "R1 idle tx", tx_o, 1);
    @(negedge clk);
    check(done_o === 1'b0, "R8 single cycle", done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tx_o === 1'b1, "R1 reset tx", tx_o, 1);
    check(busy_o === 1'b0, "R1 reset busy", busy_o, 0);
    check(done_o === 1'b0, "R1 reset done", done_o, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    check(busy_o === 1'b0, "R1 idle after reset", busy_o, 0);

    for (int i = 0; i < NVEC; i++) run_hdr(VEC[i], i[0]);

    // first break bit appears only after the first tick following start
    @(negedge clk);
    auto_i = 1'b1; brk_code_i = 2'd0; dly_code_i = 2'd0; id_i = 6'h05; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(tx_o === 1'b1, "R10 no bit before tick", tx_o, 1);
    wait_tick();
    check(tx_o === 1'b0, "R10 break on first tick", tx_o, 0);
    wait_tick();
    wait_tick();
    rst_ni = 1'b0;
    #1;
    check(tx_o === 1'b1, "R1 reset mid header tx", tx_o, 1);
    check(busy_o === 1'b0, "R1 reset mid header busy", busy_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (8) @(negedge clk);
    check(busy_o === 1'b0 && tx_o === 1'b1, "R1 stays idle", {busy_o, tx_o}, 2'b01);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule